// File: doc/BRIEF.md
# Radix-2 Carry-Save Montgomery Multiplier

This block computes the Montgomery product Z = X·Y·2^(-N) mod M for an odd N-bit modulus M and operands X, Y below M. It consumes one bit of X per clock, least significant bit first. A pulse on `start` captures the three operands. `done` pulses once when `z_out` holds the fully reduced result.

Inside the loop the running partial sum is held as two vectors, a sum vector and a carry vector, so no iteration contains a long carry chain. Each step computes the reduction bit q from the low bits of the two vectors and x·Y[0]. It then folds the partial sum, the carry vector, the gated multiplicand and the gated modulus into a new pair, using two cascaded 3-to-2 compressors. The pair is halved by dropping its always-zero low bit. After N steps, one carry-propagate addition joins the pair, and at most one subtraction of M brings the value into [0, M).

Top module: `mont_mul_csa`

## Requirements
- R1: While and right after reset, `done` is 0 and `z_out` is 0.
- R2: A high `start` sampled at a rising edge, while no product is in progress, captures `x_in`, `y_in` and `m_in`. For odd M with X, Y < M, the result is the unique Z in [0, M) with Z·2^N ≡ X·Y (mod M).
- R3: Every result presented with `done` is strictly less than the captured modulus, including M = 1 and M = 2^N − 1.
- R4: `done` is high for exactly one cycle. Counting the edge that samples `start` as edge 1, `done` and the new `z_out` appear after edge N+2.
- R5: `z_out` holds its value after `done` falls, until the next product completes.
- R6: A high `start` during a product in progress is ignored. Neither the result nor the completion time of that product changes.
- R7: X = 0 or Y = 0 yields Z = 0.
- R8: A `start` sampled in the cycle where `done` is high begins a new product with the full R4 latency and a correct R2 result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a product with the present operands |
| x_in | input | N | Multiplier X, scanned bit-serially from bit 0 |
| y_in | input | N | Multiplicand Y |
| m_in | input | N | Odd modulus M |
| done | output | 1 | One-cycle result strobe |
| z_out | output | N | Montgomery product, held until the next completion |

## Verification
A wrong q bit, or a corrupted sum or carry vector, does not show at the ports until `done`, N+2 cycles after `start`. It then appears as a wrong or out-of-range `z_out`. The bench therefore compares every result against a reference computed by brute-force search for Z with Z·2^N ≡ X·Y mod M. The reference is chosen to have nothing in common with the shift-and-add loop. A control fault shows up sooner, as a `done` strobe off by even one cycle from the N+2 count, or one that lasts two cycles.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mm_state_e;

    function automatic logic xor3(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mm_csa32.sv
module mm_csa32 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s,
    output logic [W-1:0] co
);
    import mm_pkg::*;

    assign co[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_sum
        assign s[i] = xor3(a[i], b[i], c[i]);
    end

    for (genvar i = 0; i < W - 1; i++) begin : g_car
        assign co[i+1] = maj3(a[i], b[i], c[i]);
    end

endmodule

// File: rtl/mm_csa42.sv
module mm_csa42 #(
    parameter int W = 8
) (
    input  logic [W-1:0] u,
    input  logic [W-1:0] v,
    input  logic [W-1:0] w,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] s1, c1;

    mm_csa32 #(.W(W)) u_lvl1 (.a(u),  .b(v),  .c(w), .s(s1), .co(c1));
    mm_csa32 #(.W(W)) u_lvl2 (.a(s1), .b(c1), .c(y), .s(s),  .co(c));

endmodule

// File: rtl/mm_final.sv
module mm_final #(
    parameter int N  = 16,
    parameter int SW = N + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sum_v,
    input  logic [SW-1:0] car_v,
    input  logic [N-1:0]  m,
    output logic [N-1:0]  z
);
    logic [SW:0] joined;
    logic [SW:0] m_ext;
    logic [SW:0] diff;
    logic        take_diff;

    assign joined    = {1'b0, sum_v} + {1'b0, car_v};
    assign m_ext     = {{(SW+1-N){1'b0}}, m};
    assign diff      = joined - m_ext;
    assign take_diff = (joined >= m_ext);
    assign z         = take_diff ? diff[N-1:0] : joined[N-1:0];

    // R3
    fin_fit_chk: assert property (@(posedge clk) disable iff (rst)
        (take_diff ? diff[SW:N] : joined[SW:N]) == '0);

endmodule

// File: rtl/mont_mul_csa.sv
module mont_mul_csa #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] x_in,
    input  logic [N-1:0] y_in,
    input  logic [N-1:0] m_in,
    output logic         done,
    output logic [N-1:0] z_out
);
    import mm_pkg::*;

    localparam int SW = N + 2;
    localparam int W  = N + 3;
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    mm_state_e     state;
    logic [CW-1:0] cnt;
    logic [N-1:0]  x_reg, y_reg, m_reg, z_q;
    logic [SW-1:0] sum_q, car_q;
    logic          done_q;

    logic          xb, qb;
    logic [W-1:0]  sum_ext, car_ext, addx, addm, red_s, red_c;
    logic [N-1:0]  fin_z;

    assign xb      = x_reg[0];
    assign qb      = sum_q[0] ^ car_q[0] ^ (xb & y_reg[0]);
    assign sum_ext = {1'b0, sum_q};
    assign car_ext = {1'b0, car_q};
    assign addx    = xb ? {3'b000, y_reg} : '0;
    assign addm    = qb ? {3'b000, m_reg} : '0;

    mm_csa42 #(.W(W)) u_red (
        .u(sum_ext), .v(car_ext), .w(addx), .y(addm),
        .s(red_s),   .c(red_c)
    );

    mm_final #(.N(N), .SW(SW)) u_fin (
        .clk(clk), .rst(rst),
        .sum_v(sum_q), .car_v(car_q), .m(m_reg), .z(fin_z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            x_reg  <= '0;
            y_reg  <= '0;
            m_reg  <= '0;
            sum_q  <= '0;
            car_q  <= '0;
            z_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        x_reg <= x_in;
                        y_reg <= y_in;
                        m_reg <= m_in;
                        sum_q <= '0;
                        car_q <= '0;
                        cnt   <= '0;
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    sum_q <= red_s[W-1:1];
                    car_q <= red_c[W-1:1];
                    x_reg <= x_reg >> 1;
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_FIN;
                end
                ST_FIN: begin
                    z_q    <= fin_z;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done  = done_q;
    assign z_out = z_q;

    // R2
    parity_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (red_s[0] == 1'b0));

    // R2
    csa_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (W'(red_s + red_c) == W'(sum_ext + car_ext + addx + addm)));

    // R3
    bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (({1'b0, sum_q} + {1'b0, car_q}) < {2'b00, m_reg, 1'b0}));

    // R3
    z_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (z_out < m_reg));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(m_reg) && $stable(y_reg)));

endmodule

// File: tb/tb_mont_mul_csa.sv
module tb_mont_mul_csa;

    localparam int N  = 16;
    localparam int NV = 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] x_in = '0, y_in = '0, m_in = '0;
    logic         done;
    logic [N-1:0] z_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mont_mul_csa #(.N(N)) dut (
        .clk(clk), .rst(rst), .start(start),
        .x_in(x_in), .y_in(y_in), .m_in(m_in),
        .done(done), .z_out(z_out)
    );

    // {x, y, m}
    localparam logic [47:0] VEC [NV] = '{
        {16'd3,     16'd5,     16'd13},
        {16'd0,     16'd1234,  16'd40961},
        {16'd1,     16'd1,     16'd65535},
        {16'd65534, 16'd65534, 16'd65535},
        {16'd12345, 16'd54321, 16'd65521},
        {16'd100,   16'd200,   16'd257},
        {16'd1,     16'd65520, 16'd65521},
        {16'd777,   16'd0,     16'd999},
        {16'd0,     16'd0,     16'd1}
    };

    function automatic longint ref_mont(longint x, longint y, longint m);
        longint target = (x * y) % m;
        for (longint z = 0; z < m; z++)
            if (((z << N) % m) == target) return z;
        return -1;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [N-1:0] x, input logic [N-1:0] y,
                          input logic [N-1:0] m, output logic [N-1:0] z, output int cyc);
        x_in = x; y_in = y; m_in = m; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 1000) begin
            @(posedge clk); #1;
            cyc++;
        end
        z = z_out;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] z;
        int cyc;
        longint e;

        repeat (3) @(posedge clk);
        #1;
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(z_out == '0, "R1 z in reset", z_out, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(z_out == '0, "R1 z after reset", z_out, 0);

        for (int i = 0; i < NV; i++) begin
            logic [N-1:0] vx, vy, vm;
            vx = VEC[i][47:32]; vy = VEC[i][31:16]; vm = VEC[i][15:0];
            e = ref_mont(vx, vy, vm);
            run_op(vx, vy, vm, z, cyc);
            check(z == e[N-1:0], "R2 product", z, e);
            check(z < vm, "R3 range", z, vm);
            check(cyc == N + 2, "R4 latency", cyc, N + 2);
            @(posedge clk); #1;
            check(done == 1'b0, "R4 single cycle", done, 0);
        end

        // R7 zero operands
        run_op(16'd0, 16'd999, 16'd1001, z, cyc);
        check(z == '0, "R7 x zero", z, 0);
        run_op(16'd4321, 16'd0, 16'd65535, z, cyc);
        check(z == '0, "R7 y zero", z, 0);

        // R5 hold
        e = ref_mont(100, 200, 257);
        run_op(16'd100, 16'd200, 16'd257, z, cyc);
        repeat (6) @(posedge clk);
        #1;
        check(z_out == e[N-1:0], "R5 hold", z_out, e);

        // R6 start ignored while busy
        e = ref_mont(12345, 54321, 65521);
        x_in = 16'd12345; y_in = 16'd54321; m_in = 16'd65521; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cyc = 1;
        repeat (3) begin @(posedge clk); #1; cyc++; end
        x_in = 16'd7; y_in = 16'd9; m_in = 16'd11; start = 1'b1;
        @(posedge clk); #1;
        cyc++;
        start = 1'b0;
        while (!done && cyc < 1000) begin @(posedge clk); #1; cyc++; end
        check(z_out == e[N-1:0], "R6 result unchanged", z_out, e);
        check(cyc == N + 2, "R6 timing unchanged", cyc, N + 2);

        // R8 back-to-back start during done
        e = ref_mont(3, 5, 13);
        run_op(16'd3, 16'd5, 16'd13, z, cyc);
        check(done == 1'b1, "R8 done seen", done, 1);
        e = ref_mont(65534, 65534, 65535);
        run_op(16'd65534, 16'd65534, 16'd65535, z, cyc);
        check(z == e[N-1:0], "R8 product", z, e);
        check(cyc == N + 2, "R8 latency", cyc, N + 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule